// File: doc/BRIEF.md
# Shared Mantissa Adder/Subtracter with Selectable Rounding

This block is the back end of a floating-point add/subtract path. The same 32-bit adder/subtracter also serves fixed-point arithmetic. It takes two mantissas that are already aligned. Each mantissa has one integer bit and 31 fraction bits. It also takes the guard and sticky bits that alignment shifted out of the second operand, plus an add/subtract select, a precision select, a fixed/float select and a two-bit rounding mode.

In floating-point mode the block does the following:
- It forms the magnitude of the sum or difference.
- It corrects the sign when a subtraction goes negative.
- It renormalizes by one place when a carry leaves the integer bit.
- It rounds at the 32-bit or the 24-bit point.
- It reports how many places the exponent must move up.

Leading-zero normalization after a subtraction is the job of a later stage.

In fixed-point mode the block bypasses sign correction and rounding. It returns the raw 32-bit two's-complement result and a carry/borrow flag. The owner places that result in the low field of the destination. Floating results go to the mantissa field.

The block has one register stage. A result appears one clock after `in_valid`, and the output registers hold their value in any cycle without `in_valid`.

Top module: `mant_addsub_round`

## Requirements
- R1: With `is_fixed`=1, `res_man` is (a+b) mod 2^32 when `op_sub`=0, or (a-b) mod 2^32 when `op_sub`=1. `cv_flag` is the carry out of the add, or the borrow (a<b) of the subtract.
- R2: With `is_fixed`=1, guard, sticky, `rnd_mode` and `fmt_single` have no effect. `exp_adj` is 0 and `res_sign` equals `sign_in`.
- R3: In float addition the operands are A·4 and B·4+guard·2+sticky. If the sum reaches 2^34, the result is shifted right one place. The shifted-out bits are folded into guard and sticky, and `exp_adj` counts one.
- R4: When a float subtraction gives a negative value, the magnitude is returned and `res_sign` = `sign_in` XOR 1. Otherwise `res_sign` = `sign_in`.
- R5: `rnd_mode` selects how a float result is rounded. 00 is nearest-even (round up when guard and (sticky or LSB)). 01 is toward zero. 10 is toward plus infinity (round up when guard or sticky and the result is positive). 11 is toward minus infinity (round up when guard or sticky and the result is negative).
- R6: With `fmt_single`=1 in float mode, rounding happens at bit 8. Bit 7 acts as guard, and bits 6..0 with the incoming guard and sticky act as sticky. `res_man[7:0]` is zero.
- R7: If rounding carries out of the kept field, the mantissa becomes 0x80000000 and `exp_adj` is raised by one more. `exp_adj` can therefore reach 2. A nonzero `exp_adj` always comes with `res_man[31]`=1.
- R8: `out_valid` equals `in_valid` of the previous cycle. Results appear one clock after `in_valid` and are held while `in_valid` is low.
- R9: While `rst_n` is low, all outputs are zero.
- R10: `cv_flag` is 0 for every float-mode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present; enables the output registers |
| a_man | input | 32 | First aligned mantissa (1.31) or fixed operand |
| b_man | input | 32 | Second aligned mantissa (1.31) or fixed operand |
| guard_in | input | 1 | First bit shifted out of b during alignment |
| sticky_in | input | 1 | OR of all further shifted-out bits |
| op_sub | input | 1 | 1 = a minus b, 0 = a plus b |
| fmt_single | input | 1 | 1 = round to 24 bits, 0 = round to 32 bits |
| is_fixed | input | 1 | 1 = fixed-point operation, no rounding |
| rnd_mode | input | 2 | 00 nearest-even, 01 zero, 10 plus inf, 11 minus inf |
| sign_in | input | 1 | Sign associated with operand a |
| out_valid | output | 1 | Result valid |
| res_man | output | 32 | Rounded mantissa or raw fixed result |
| res_sign | output | 1 | Result sign |
| exp_adj | output | 2 | Exponent increment from renormalization (0..2) |
| cv_flag | output | 1 | Fixed-point carry (add) or borrow (subtract) |

## Verification
The checker watches several properties on every cycle:
- the valid pipeline and the holding of results while no operation is presented;
- the zeroed low byte of every 24-bit result;
- the silence of the exponent increment and the carry flag in the mode where each does not apply;
- the link between a nonzero exponent increment and a set top bit.

The arithmetic itself can only be shown by the bench's directed scenarios, which compare against a model built on scaled integers. These scenarios cover the carry/borrow values, negative differences and sign flips, each rounding mode on ties and on sticky-only remainders, the double exponent increment when rounding overflows, and the fact that fixed mode ignores rounding controls.

// File: rtl/mant_rnd_pkg.sv
package mant_rnd_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS_INF   = 2'b10,
    RND_NEG_INF   = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/mant_addsub.sv
// Shared adder/subtracter over an extended word: {carry, mantissa, guard, sticky}.
module mant_addsub #(
  parameter int MAN_W = 32
) (
  input  logic [MAN_W-1:0] a_man,
  input  logic [MAN_W-1:0] b_man,
  input  logic             guard_in,
  input  logic             sticky_in,
  input  logic             op_sub,
  input  logic             is_fixed,
  output logic [MAN_W+2:0] mag,
  output logic             neg
);
  localparam int EXT_W = MAN_W + 3;

  logic [EXT_W-1:0] ext_a, ext_b, raw;

  always_comb begin
    ext_a = {1'b0, a_man, 2'b00};
    // fixed point discards alignment bits so the carry lands at the word top
    ext_b = {1'b0, b_man, (is_fixed ? 2'b00 : {guard_in, sticky_in})};
    raw   = op_sub ? (ext_a - ext_b) : (ext_a + ext_b);
    neg   = op_sub & ~is_fixed & raw[EXT_W-1];
    mag   = neg ? (~raw + {{(EXT_W-1){1'b0}}, 1'b1}) : raw;
  end
endmodule

// File: rtl/mant_rnd_inc.sv
// Rounding increment for one precision lane.
module mant_rnd_inc
  import mant_rnd_pkg::*;
#(
  parameter int KEEP_W = 32
) (
  input  logic [KEEP_W-1:0] keep,
  input  logic              g,
  input  logic              s,
  input  rnd_mode_e         mode,
  input  logic              sign,
  output logic [KEEP_W-1:0] rnd,
  output logic              ovf
);
  logic          up;
  logic [KEEP_W:0] sum;

  always_comb begin
    unique case (mode)
      RND_NEAR_EVEN: up = g & (s | keep[0]);
      RND_ZERO:      up = 1'b0;
      RND_POS_INF:   up = (g | s) & ~sign;
      RND_NEG_INF:   up = (g | s) & sign;
      default:       up = 1'b0;
    endcase
    sum = {1'b0, keep} + {{KEEP_W{1'b0}}, up};
    ovf = sum[KEEP_W];
    rnd = ovf ? {1'b1, {(KEEP_W-1){1'b0}}} : sum[KEEP_W-1:0];
  end
endmodule

// File: rtl/mant_rounder.sv
// Carry renormalization followed by rounding at the wide or short point.
module mant_rounder
  import mant_rnd_pkg::*;
#(
  parameter int MAN_W   = 32,
  parameter int SHORT_W = 24
) (
  input  logic [MAN_W+2:0] mag,
  input  rnd_mode_e        mode,
  input  logic             sign,
  input  logic             fmt_single,
  output logic [MAN_W-1:0] man,
  output logic [1:0]       adj
);
  localparam int EXT_W = MAN_W + 3;
  localparam int DROP  = MAN_W - SHORT_W;

  logic             carry, g0, s0;
  logic [MAN_W-1:0] norm;

  always_comb begin
    carry = mag[EXT_W-1];
    norm  = carry ? mag[EXT_W-1:3] : mag[EXT_W-2:2];
    g0    = carry ? mag[2] : mag[1];
    s0    = carry ? (mag[1] | mag[0]) : mag[0];
  end

  logic [MAN_W-1:0]   wide_rnd;
  logic               wide_ovf;
  logic [SHORT_W-1:0] short_rnd;
  logic               short_ovf;
  logic               short_g, short_s;

  always_comb begin
    short_g = norm[DROP-1];
    short_s = (|norm[DROP-2:0]) | g0 | s0;
  end

  mant_rnd_inc #(.KEEP_W(MAN_W)) u_wide (
    .keep(norm), .g(g0), .s(s0), .mode(mode), .sign(sign),
    .rnd(wide_rnd), .ovf(wide_ovf)
  );

  mant_rnd_inc #(.KEEP_W(SHORT_W)) u_short (
    .keep(norm[MAN_W-1:DROP]), .g(short_g), .s(short_s), .mode(mode), .sign(sign),
    .rnd(short_rnd), .ovf(short_ovf)
  );

  always_comb begin
    man = fmt_single ? {short_rnd, {DROP{1'b0}}} : wide_rnd;
    adj = {1'b0, carry} + {1'b0, (fmt_single ? short_ovf : wide_ovf)};
  end
endmodule

// File: rtl/mant_addsub_round.sv
module mant_addsub_round
  import mant_rnd_pkg::*;
#(
  parameter int MAN_W   = 32,
  parameter int SHORT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      a_man,
  input  logic [31:0]      b_man,
  input  logic             guard_in,
  input  logic             sticky_in,
  input  logic             op_sub,
  input  logic             fmt_single,
  input  logic             is_fixed,
  input  logic [1:0]       rnd_mode,
  input  logic             sign_in,
  output logic             out_valid,
  output logic [31:0]      res_man,
  output logic             res_sign,
  output logic [1:0]       exp_adj,
  output logic             cv_flag
);
  localparam int EXT_W = MAN_W + 3;

  logic [EXT_W-1:0] mag;
  logic             neg;
  logic [MAN_W-1:0] rnd_man;
  logic [1:0]       rnd_adj;
  logic             eff_sign;

  mant_addsub #(.MAN_W(MAN_W)) u_addsub (
    .a_man(a_man), .b_man(b_man), .guard_in(guard_in), .sticky_in(sticky_in),
    .op_sub(op_sub), .is_fixed(is_fixed), .mag(mag), .neg(neg)
  );

  assign eff_sign = sign_in ^ neg;

  mant_rounder #(.MAN_W(MAN_W), .SHORT_W(SHORT_W)) u_round (
    .mag(mag), .mode(rnd_mode_e'(rnd_mode)), .sign(eff_sign),
    .fmt_single(fmt_single), .man(rnd_man), .adj(rnd_adj)
  );

  // next-state
  logic [MAN_W-1:0] man_d;
  logic             sign_d, cv_d;
  logic [1:0]       adj_d;

  always_comb begin
    man_d  = is_fixed ? mag[EXT_W-2:2] : rnd_man;
    sign_d = eff_sign;
    adj_d  = is_fixed ? 2'b00 : rnd_adj;
    cv_d   = is_fixed & mag[EXT_W-1];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_man   <= '0;
      res_sign  <= 1'b0;
      exp_adj   <= 2'b00;
      cv_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_man  <= man_d;
        res_sign <= sign_d;
        exp_adj  <= adj_d;
        cv_flag  <= cv_d;
      end
    end
  end
endmodule

// File: rtl/mant_addsub_round_chk.sv
module mant_addsub_round_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        fmt_single,
  input logic        is_fixed,
  input logic        sign_in,
  input logic        out_valid,
  input logic [31:0] res_man,
  input logic        res_sign,
  input logic [1:0]  exp_adj,
  input logic        cv_flag
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_man) && $stable(exp_adj) && $stable(res_sign)));  // R8
  AST_SHORT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_single && !is_fixed) |=> (res_man[7:0] == 8'h00));  // R6
  AST_FIXED_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_fixed) |=> (exp_adj == 2'b00 && res_sign == $past(sign_in)));  // R2
  AST_FLOAT_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_fixed) |=> !cv_flag);  // R10
  AST_ADJ_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exp_adj != 2'b00) |-> res_man[31]);  // R7
endmodule

bind mant_addsub_round mant_addsub_round_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_single(fmt_single),
  .is_fixed(is_fixed), .sign_in(sign_in), .out_valid(out_valid),
  .res_man(res_man), .res_sign(res_sign), .exp_adj(exp_adj), .cv_flag(cv_flag)
);

// File: tb/sim_mant_addsub_round.sv
`timescale 1ns/1ps
module sim_mant_addsub_round;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] a_man, b_man;
  logic        guard_in, sticky_in, op_sub, fmt_single, is_fixed, sign_in;
  logic [1:0]  rnd_mode;
  logic        out_valid, res_sign, cv_flag;
  logic [31:0] res_man;
  logic [1:0]  exp_adj;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mant_addsub_round u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_man(a_man), .b_man(b_man),
    .guard_in(guard_in), .sticky_in(sticky_in), .op_sub(op_sub),
    .fmt_single(fmt_single), .is_fixed(is_fixed), .rnd_mode(rnd_mode),
    .sign_in(sign_in), .out_valid(out_valid), .res_man(res_man),
    .res_sign(res_sign), .exp_adj(exp_adj), .cv_flag(cv_flag)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scaled-integer model of the requirements
  task automatic model(input logic [31:0] a, input logic [31:0] b, input bit g, input bit s,
                       input bit sub, input bit single, input bit fixed, input bit [1:0] mode,
                       input bit sgn, output logic [31:0] e_man, output bit e_sign,
                       output int e_adj, output bit e_cv);
    longint x, y, d, q, rem, half, lim;
    int drop;
    bit rg, rs, up;
    if (fixed) begin
      x = longint'(a); y = longint'(b);
      d = sub ? x - y : x + y;
      e_man = d[31:0];
      e_cv  = sub ? (a < b) : (d >= 64'sh1_0000_0000);
      e_sign = sgn; e_adj = 0;
      return;
    end
    e_cv = 0; e_adj = 0;
    x = longint'(a) * 4;
    y = longint'(b) * 4 + (g ? 2 : 0) + (s ? 1 : 0);
    d = sub ? x - y : x + y;
    e_sign = sgn;
    if (d < 0) begin d = -d; e_sign = ~sgn; end
    if (d >= (64'sd1 << 34)) begin d = (d >> 1) | (d & 1); e_adj = 1; end
    drop = single ? 10 : 2;
    half = 64'sd1 << (drop - 1);
    q    = d >> drop;
    rem  = d & ((64'sd1 << drop) - 1);
    rg   = (rem >= half);
    rs   = ((rem % half) != 0);
    case (mode)
      2'b00: up = rg && (rs || q[0]);
      2'b01: up = 0;
      2'b10: up = (rg || rs) && !e_sign;
      default: up = (rg || rs) && e_sign;
    endcase
    q   = q + (up ? 1 : 0);
    lim = 64'sd1 << (single ? 24 : 32);
    if (q >= lim) begin q = q >> 1; e_adj++; end
    if (single) q = q << 8;
    e_man = q[31:0];
  endtask

  task automatic run_op(string req, logic [31:0] a, logic [31:0] b, bit g, bit s, bit sub,
                        bit single, bit fixed, bit [1:0] mode, bit sgn);
    logic [31:0] e_man; bit e_sign; int e_adj; bit e_cv;
    model(a, b, g, s, sub, single, fixed, mode, sgn, e_man, e_sign, e_adj, e_cv);
    @(negedge clk);
    in_valid = 1; a_man = a; b_man = b; guard_in = g; sticky_in = s; op_sub = sub;
    fmt_single = single; is_fixed = fixed; rnd_mode = mode; sign_in = sgn;
    @(negedge clk);
    in_valid = 0;
    check(req, "out_valid", longint'(out_valid), 1);
    check(req, "res_man", longint'(res_man), longint'(e_man));
    check(req, "res_sign", longint'(res_sign), longint'(e_sign));
    check(req, "exp_adj", longint'(exp_adj), longint'(e_adj));
    check(req, "cv_flag", longint'(cv_flag), longint'(e_cv));
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; a_man = 0; b_man = 0; guard_in = 0; sticky_in = 0;
    op_sub = 0; fmt_single = 0; is_fixed = 0; rnd_mode = 0; sign_in = 0;
    repeat (3) @(negedge clk);
    check("R9", "out_valid", longint'(out_valid), 0);
    check("R9", "res_man", longint'(res_man), 0);
    check("R9", "exp_adj", longint'(exp_adj), 0);
    check("R9", "flags", longint'({res_sign, cv_flag}), 0);
    rst_n = 1;
  endtask

  task automatic t_fixed();
    run_op("R1", 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 1, 2'b00, 0);
    check("R1", "hand carry", longint'({cv_flag, res_man}), 64'h1_0000_0000);
    run_op("R1", 32'h0000_0005, 32'h0000_0007, 0, 0, 1, 0, 1, 2'b00, 0);
    check("R1", "hand borrow", longint'({cv_flag, res_man}), 64'h1_FFFF_FFFE);
    run_op("R1", 32'h1234_5678, 32'h0101_0101, 0, 0, 1, 0, 1, 2'b00, 1);
    // R2: guard, sticky, mode and format ignored
    run_op("R2", 32'h7FFF_FFFF, 32'h0000_0001, 1, 1, 0, 1, 1, 2'b10, 1);
    check("R2", "hand raw", longint'(res_man), 64'h8000_0000);
  endtask

  task automatic t_float_add();
    run_op("R3", 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, 0, 2'b00, 0);
    check("R3", "hand renorm", longint'({exp_adj, res_man}), 64'h1_8000_0000);
    run_op("R3", 32'hC000_0001, 32'h4000_0000, 1, 0, 0, 0, 0, 2'b00, 0);
    run_op("R3", 32'h4000_0000, 32'h2000_0000, 1, 1, 0, 0, 0, 2'b01, 0);
  endtask

  task automatic t_float_sub();
    run_op("R4", 32'h4000_0000, 32'h6000_0000, 0, 0, 1, 0, 0, 2'b00, 0);
    check("R4", "hand neg", longint'({res_sign, res_man}), 64'h1_2000_0000);
    run_op("R4", 32'h8000_0000, 32'h0000_0001, 1, 1, 1, 0, 0, 2'b00, 1);
    run_op("R4", 32'h1000_0000, 32'h1000_0000, 0, 1, 1, 0, 0, 2'b10, 0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      run_op("R5", 32'h8000_0002, 32'h0, 1, 0, 0, 0, 0, 2'(m), 0);
      run_op("R5", 32'h8000_0003, 32'h0, 1, 0, 0, 0, 0, 2'(m), 1);
      run_op("R5", 32'h8000_0002, 32'h0, 0, 1, 0, 0, 0, 2'(m), 1);
      run_op("R5", 32'h9000_0000, 32'h0000_0001, 0, 1, 1, 0, 0, 2'(m), 0);
    end
    run_op("R5", 32'h8000_0003, 32'h0, 1, 0, 0, 0, 0, 2'b00, 0);
    check("R5", "hand tie odd", longint'(res_man), 64'h8000_0004);
  endtask

  task automatic t_single();
    for (int m = 0; m < 4; m++) begin
      run_op("R6", 32'h8000_0180, 32'h0, 0, 0, 0, 1, 0, 2'(m), 0);
      run_op("R6", 32'h8000_0080, 32'h0, 0, 0, 0, 1, 0, 2'(m), 1);
      run_op("R6", 32'h8000_0000, 32'h0, 0, 1, 0, 1, 0, 2'(m), 0);
      run_op("R6", 32'hF123_4567, 32'h1234_5678, 1, 1, 0, 1, 0, 2'(m), 1);
    end
    run_op("R6", 32'h8000_0180, 32'h0, 0, 0, 0, 1, 0, 2'b00, 0);
    check("R6", "hand short tie", longint'(res_man), 64'h8000_0200);
  endtask

  task automatic t_round_ovf();
    run_op("R7", 32'hFFFF_FFFF, 32'h0, 1, 1, 0, 0, 0, 2'b00, 0);
    check("R7", "hand wide ovf", longint'({exp_adj, res_man}), 64'h1_8000_0000);
    run_op("R7", 32'hFFFF_FF80, 32'h0, 0, 0, 0, 1, 0, 2'b00, 0);
    check("R7", "hand short ovf", longint'({exp_adj, res_man}), 64'h1_8000_0000);
    run_op("R7", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 0, 0, 0, 2'b10, 0);
    check("R7", "hand double adj", longint'(exp_adj), 2);
    check("R10", "float cv", longint'(cv_flag), 0);
  endtask

  task automatic t_hold();
    logic [31:0] keep_man;
    run_op("R8", 32'h2345_6789, 32'h1111_1111, 0, 0, 0, 0, 0, 2'b00, 0);
    keep_man = res_man;
    a_man = 32'hFFFF_FFFF; b_man = 32'hFFFF_FFFF; is_fixed = 1; sign_in = 1;
    repeat (2) @(negedge clk);
    check("R8", "idle valid", longint'(out_valid), 0);
    check("R8", "idle hold man", longint'(res_man), longint'(keep_man));
    check("R8", "idle hold flags", longint'({res_sign, cv_flag, exp_adj}), 0);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_float_add();
    t_float_sub();
    t_modes();
    t_single();
    t_round_ovf();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule